// File: doc/BRIEF.md
# Dual-view GPIO controller with level interrupts

This block holds the configuration and interrupt state of 24 general-purpose pins in one shared set of registers and exposes that state through two register windows on a single-cycle register bus. The full window is open only to a privileged requester and reads every pin. The restricted window is open to any requester but reaches only the pins that an owner mask hands to it. Because both windows address the same storage, moving a pin between windows needs no copying: its existing settings appear in the other window as soon as the owner bit changes.

Each pin has an output value, a direction, a synchronized input, an interrupt level, a sticky interrupt flag and an interrupt mask. A flag is raised while an enabled pin sits at its selected level. It cannot be cleared until the pin leaves that level. There are two interrupt outputs, one for the pins each window owns. A snapshot of the pin inputs is captured once after reset and stays readable from then on.

Top module: `gpio_dual_view`

## Requirements
- R1: The bus word index `bus_addr_i[5:2]` selects a register. Indices 0 to 6 are the restricted window: output, direction, input, level, flag, mask and snapshot, in that order. Index 7 is the pin enable. Indices 8 to 14 are the full window, with the same seven registers in the same order. Index 15 is the owner mask. Read data bits 31:24 are always zero. After reset every register reads zero except the snapshot.
- R2: `pin_oe_o` is high for pins whose direction bit and enable bit are both 1. `pin_out_o` carries the output register bit for such pins and is 0 for every other pin.
- R3: The input register shows `pin_in_i` delayed by two rising clock edges.
- R4: An enabled pin whose synchronized input equals its level bit raises its flag on the next edge. A level bit of 1 means active high and 0 means active low. A pin whose enable bit is 0 never raises a flag.
- R5: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. While the pin stays at its active level, the flag remains 1 even when a clear is written.
- R6: A latched flag can be cleared once the pin has left its active level, or once its level bit has been inverted.
- R7: An owner bit of 1 gives the pin to the restricted window. Full-window writes leave owned bits unchanged. Full-window reads return all pins.
- R8: Through the restricted window, pins that are not owned read as 0, and writes to them have no effect.
- R9: Both windows share one storage. Changing an owner bit makes the pin's current settings readable in the newly owning window at once.
- R10: `irq_full_o` is the OR over the bits of mask AND flag AND NOT owner. `irq_restr_o` is the OR over the bits of mask AND flag AND owner. Flags of masked-off pins still latch and can still be read and cleared.
- R11: When `bus_priv_i` is 0, accesses to indices 7 to 15 read zero and have no effect. The restricted window works for both privilege levels.
- R12: The snapshot register takes the synchronized inputs on the third rising edge after reset is released. After that it is read-only and stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_priv_i | input | 1 | Requester is privileged |
| bus_addr_i | input | 6 | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not selected |
| pin_in_i | input | 24 | Pin input levels |
| pin_out_o | output | 24 | Pin output values |
| pin_oe_o | output | 24 | Pin output enables |
| irq_full_o | output | 1 | Interrupt for pins held by the full window |
| irq_restr_o | output | 1 | Interrupt for pins owned by the restricted window |

## Verification
The flag logic is driven with a pin that rises and falls against both level settings. This separates a clear attempted while the pin is still active, which must fail, from one attempted after the pin has gone idle or after its level has been inverted, which must succeed. A disabled pin at its active level shows that the enable gates flag setting. Owner masks that split the pins between the windows are written from both sides, which distinguishes the partitioned write and read masks from plain shared access. The same split, with pins raised in one window and then in the other, checks that each interrupt line reports only its own pins and that masked flags still latch.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;
    localparam int unsigned ADDR_W = 6;

    typedef enum logic [3:0] {
        RK_OUT    = 4'd0,
        RK_DIR    = 4'd1,
        RK_IN     = 4'd2,
        RK_LVL    = 4'd3,
        RK_FLAG   = 4'd4,
        RK_MASK   = 4'd5,
        RK_MIR    = 4'd6,
        RK_ENABLE = 4'd7,
        RK_OWNER  = 4'd8,
        RK_NONE   = 4'd9
    } reg_kind_e;

    localparam logic [3:0] IDX_ENABLE = 4'd7;
    localparam logic [3:0] IDX_FULL   = 4'd8;
    localparam logic [3:0] IDX_OWNER  = 4'd15;
endpackage

// File: rtl/gpio_dv_sync.sv
module gpio_dv_sync #(
    parameter int unsigned W      = 24,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d_i;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_dv_decode.sv
module gpio_dv_decode
    import gpio_dv_pkg::*;
#(
    parameter int unsigned NPINS = 24
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              priv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]  owner_i,
    output reg_kind_e         kind_o,
    output logic [NPINS-1:0]  wmask_o,
    output logic [NPINS-1:0]  rmask_o
);
    logic [3:0]       idx;
    logic [NPINS-1:0] lane;
    logic             allowed;
    logic             full_win;
    logic [1:0]       unused_byte_sel;

    assign idx             = addr_i[ADDR_W-1:2];
    assign unused_byte_sel = addr_i[1:0];

    always_comb begin
        kind_o   = RK_NONE;
        lane     = '0;
        allowed  = 1'b0;
        full_win = 1'b0;
        if (idx < IDX_ENABLE) begin
            kind_o  = reg_kind_e'(idx);
            lane    = owner_i;
            allowed = 1'b1;
        end else if (idx == IDX_ENABLE) begin
            kind_o   = RK_ENABLE;
            lane     = '1;
            allowed  = priv_i;
            full_win = 1'b1;
        end else if (idx == IDX_OWNER) begin
            kind_o   = RK_OWNER;
            lane     = '1;
            allowed  = priv_i;
            full_win = 1'b1;
        end else begin
            kind_o   = reg_kind_e'(idx - IDX_FULL);
            lane     = ~owner_i;
            allowed  = priv_i;
            full_win = 1'b1;
        end
        rmask_o = (sel_i && allowed) ? (full_win ? '1 : lane) : '0;
        wmask_o = (sel_i && wr_i && allowed) ? lane : '0;
    end
endmodule

// File: rtl/gpio_dv_rdmux.sv
module gpio_dv_rdmux
    import gpio_dv_pkg::*;
#(
    parameter int unsigned NPINS = 24,
    parameter int unsigned DW    = 32
) (
    input  reg_kind_e        kind_i,
    input  logic [NPINS-1:0] rmask_i,
    input  logic [NPINS-1:0] out_i,
    input  logic [NPINS-1:0] dir_i,
    input  logic [NPINS-1:0] in_i,
    input  logic [NPINS-1:0] lvl_i,
    input  logic [NPINS-1:0] flag_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic [NPINS-1:0] mir_i,
    input  logic [NPINS-1:0] en_i,
    input  logic [NPINS-1:0] own_i,
    output logic [DW-1:0]    rdata_o
);
    localparam int unsigned PAD_W = DW - NPINS;
    logic [NPINS-1:0] val;

    always_comb begin
        unique case (kind_i)
            RK_OUT:    val = out_i;
            RK_DIR:    val = dir_i;
            RK_IN:     val = in_i;
            RK_LVL:    val = lvl_i;
            RK_FLAG:   val = flag_i;
            RK_MASK:   val = mask_i;
            RK_MIR:    val = mir_i;
            RK_ENABLE: val = en_i;
            RK_OWNER:  val = own_i;
            default:   val = '0;
        endcase
        rdata_o = {{PAD_W{1'b0}}, val & rmask_i};
    end
endmodule

// File: rtl/gpio_dual_view.sv
module gpio_dual_view
    import gpio_dv_pkg::*;
#(
    parameter int unsigned NPINS = 24,
    parameter int unsigned DW    = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic              bus_priv_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic [NPINS-1:0]  pin_in_i,
    output logic [NPINS-1:0]  pin_out_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic              irq_full_o,
    output logic              irq_restr_o
);
    localparam int unsigned SYNC_STAGES = 2;
    localparam logic [1:0]  SNAP_TAKE   = 2'd2;
    localparam logic [1:0]  SNAP_DONE   = 2'd3;

    typedef struct packed {
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] lvl;
        logic [NPINS-1:0] flag;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] own;
        logic [NPINS-1:0] mir;
        logic [1:0]       snap;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] in_sync;
    logic [NPINS-1:0] active;
    logic [NPINS-1:0] wmask;
    logic [NPINS-1:0] rmask;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] clr;
    reg_kind_e        kind;
    logic [DW-NPINS-1:0] unused_wdata_hi;

    // Signals observed by the bound checker
    logic [NPINS-1:0] flag_w, own_w, en_w, out_w, mir_w;
    logic             snap_done;

    assign unused_wdata_hi = bus_wdata_i[DW-1:NPINS];
    assign wbits           = bus_wdata_i[NPINS-1:0];

    gpio_dv_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_in_i),
        .q_o    (in_sync)
    );

    gpio_dv_decode #(.NPINS(NPINS)) u_dec (
        .sel_i   (bus_sel_i),
        .wr_i    (bus_wr_i),
        .priv_i  (bus_priv_i),
        .addr_i  (bus_addr_i),
        .owner_i (st_q.own),
        .kind_o  (kind),
        .wmask_o (wmask),
        .rmask_o (rmask)
    );

    gpio_dv_rdmux #(.NPINS(NPINS), .DW(DW)) u_rd (
        .kind_i  (kind),
        .rmask_i (rmask),
        .out_i   (st_q.out),
        .dir_i   (st_q.dir),
        .in_i    (in_sync),
        .lvl_i   (st_q.lvl),
        .flag_i  (st_q.flag),
        .mask_i  (st_q.mask),
        .mir_i   (st_q.mir),
        .en_i    (st_q.en),
        .own_i   (st_q.own),
        .rdata_o (bus_rdata_o)
    );

    // Pin sits at its selected level and is enabled
    assign active = st_q.en & ~(in_sync ^ st_q.lvl);

    always_comb begin
        st_d = st_q;
        clr  = '0;
        unique case (kind)
            RK_OUT:    st_d.out  = (st_q.out  & ~wmask) | (wbits & wmask);
            RK_DIR:    st_d.dir  = (st_q.dir  & ~wmask) | (wbits & wmask);
            RK_LVL:    st_d.lvl  = (st_q.lvl  & ~wmask) | (wbits & wmask);
            RK_MASK:   st_d.mask = (st_q.mask & ~wmask) | (wbits & wmask);
            RK_ENABLE: st_d.en   = (st_q.en   & ~wmask) | (wbits & wmask);
            RK_OWNER:  st_d.own  = (st_q.own  & ~wmask) | (wbits & wmask);
            RK_FLAG:   clr       = wbits & wmask;
            default:   ;
        endcase
        // Setting wins over clearing: a flag cannot drop while its pin is active
        st_d.flag = (st_q.flag & ~clr) | active;
        if (st_q.snap != SNAP_DONE) begin
            st_d.snap = st_q.snap + 2'd1;
        end
        if (st_q.snap == SNAP_TAKE) begin
            st_d.mir = in_sync;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pin_oe_o    = st_q.dir & st_q.en;
    assign pin_out_o   = st_q.out & pin_oe_o;
    assign irq_full_o  = |(st_q.mask & st_q.flag & ~st_q.own);
    assign irq_restr_o = |(st_q.mask & st_q.flag & st_q.own);

    assign flag_w    = st_q.flag;
    assign own_w     = st_q.own;
    assign en_w      = st_q.en;
    assign out_w     = st_q.out;
    assign mir_w     = st_q.mir;
    assign snap_done = (st_q.snap == SNAP_DONE);
endmodule

// File: rtl/gpio_dv_chk.sv
module gpio_dv_chk
    import gpio_dv_pkg::*;
#(
    parameter int unsigned NPINS = 24,
    parameter int unsigned DW    = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic              bus_priv_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DW-1:0]     bus_rdata_o,
    input logic [NPINS-1:0]  pin_oe_o,
    input logic              irq_full_o,
    input logic              irq_restr_o,
    input logic [NPINS-1:0]  flag_w,
    input logic [NPINS-1:0]  active,
    input logic [NPINS-1:0]  own_w,
    input logic [NPINS-1:0]  en_w,
    input logic [NPINS-1:0]  out_w,
    input logic [NPINS-1:0]  mir_w,
    input logic              snap_done
);
    localparam logic [ADDR_W-1:0] FULL_OUT_ADDR = ADDR_W'(32);

    assert_high_bits_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[DW-1:NPINS] == '0);

    assert_no_drive_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_oe_o & ~en_w) == '0);

    assert_flag_only_on_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((~$past(flag_w) & ~$past(active) & flag_w) == '0));

    assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(active) & ~flag_w) == '0));

    assert_full_skips_owned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_wr_i && bus_priv_i && bus_addr_i == FULL_OUT_ADDR)
        |=> (((out_w ^ $past(out_w)) & $past(own_w)) == '0));

    assert_irq_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_w == '0) |-> (!irq_full_o && !irq_restr_o));

    assert_unpriv_ctrl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_wr_i && !bus_priv_i && bus_addr_i[ADDR_W-1])
        |=> (own_w == $past(own_w) && en_w == $past(en_w)));

    assert_mirror_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snap_done |=> $stable(mir_w));
endmodule

bind gpio_dual_view gpio_dv_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_priv_i  (bus_priv_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_oe_o    (pin_oe_o),
    .irq_full_o  (irq_full_o),
    .irq_restr_o (irq_restr_o),
    .flag_w      (flag_w),
    .active      (active),
    .own_w       (own_w),
    .en_w        (en_w),
    .out_w       (out_w),
    .mir_w       (mir_w),
    .snap_done   (snap_done)
);

// File: tb/tb_gpio_dual_view.sv
module tb_gpio_dual_view;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, priv = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [23:0] pins = 24'h00A5C3;
    logic [23:0] pout, poe;
    logic        irq_f, irq_r;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    // Byte offsets
    localparam logic [5:0] R_OUT = 6'h00, R_DIR = 6'h04, R_FLAG = 6'h10, R_MASK = 6'h14, R_MIR = 6'h18;
    localparam logic [5:0] C_EN = 6'h1C, F_OUT = 6'h20, F_DIR = 6'h24, F_IN = 6'h28, F_LVL = 6'h2C;
    localparam logic [5:0] F_FLAG = 6'h30, F_MASK = 6'h34, F_MIR = 6'h38, C_OWN = 6'h3C;

    always #4 clk = ~clk;

    gpio_dual_view dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_priv_i(priv),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_in_i(pins),
        .pin_out_o(pout), .pin_oe_o(poe), .irq_full_o(irq_f), .irq_restr_o(irq_r)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; priv = p; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; priv = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, input logic p, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; priv = p; addr = a;
        #2;
        d = rdata;
        #1;
        sel = 1'b0; priv = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [5:0] a, input logic p, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(a, p, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 out reset", F_OUT, 1'b1, 32'h0);
        expect_reg("R1 dir reset", F_DIR, 1'b1, 32'h0);
        expect_reg("R1 enable reset", C_EN, 1'b1, 32'h0);
        expect_reg("R1 owner reset", C_OWN, 1'b1, 32'h0);
        expect_reg("R1 flag reset", F_FLAG, 1'b1, 32'h0);
        chk("R1 irq reset", {30'd0, irq_f, irq_r}, 32'h0);
        chk("R2 oe reset", {8'd0, poe}, 32'h0);
        expect_reg("R12 snapshot", F_MIR, 1'b1, 32'h00A5C3);
        wr_reg(F_MASK, 32'hFFFF_FFFF, 1'b1);
        expect_reg("R1 upper bits zero", F_MASK, 1'b1, 32'h00FF_FFFF);
        wr_reg(F_MASK, 32'h0, 1'b1);
    endtask

    task automatic t_drive;
        wr_reg(C_EN, 32'hFFFFFF, 1'b1);
        wr_reg(F_OUT, 32'h123456, 1'b1);
        wr_reg(F_DIR, 32'h00FF0F, 1'b1);
        chk("R2 oe", {8'd0, poe}, 32'h00FF0F);
        chk("R2 out gated by dir", {8'd0, pout}, 32'h003406);
        wr_reg(C_EN, 32'h00000F, 1'b1);
        chk("R2 oe gated by enable", {8'd0, poe}, 32'h00000F);
        chk("R2 out gated by enable", {8'd0, pout}, 32'h000006);
        wr_reg(C_EN, 32'hFFFFFF, 1'b1);
    endtask

    task automatic t_sync;
        @(negedge clk);
        pins = 24'h3C3C3C;
        waitc(1);
        expect_reg("R3 input after one edge", F_IN, 1'b1, 32'h00A5C3);
        waitc(1);
        expect_reg("R3 input after two edges", F_IN, 1'b1, 32'h3C3C3C);
    endtask

    task automatic t_flags;
        @(negedge clk);
        pins = 24'h0;
        wr_reg(F_LVL, 32'hFFFFFF, 1'b1);
        waitc(3);
        wr_reg(F_FLAG, 32'hFFFFFF, 1'b1);
        expect_reg("R6 flags cleared when idle", F_FLAG, 1'b1, 32'h0);
        pins = 24'h000020;
        waitc(2);
        expect_reg("R4 flag not yet set", F_FLAG, 1'b1, 32'h0);
        waitc(1);
        expect_reg("R4 flag set active high", F_FLAG, 1'b1, 32'h000020);
        wr_reg(F_FLAG, 32'h000020, 1'b1);
        expect_reg("R5 clear while active ignored", F_FLAG, 1'b1, 32'h000020);
        wr_reg(F_FLAG, 32'h0, 1'b1);
        expect_reg("R5 write zero no effect", F_FLAG, 1'b1, 32'h000020);
        pins = 24'h0;
        waitc(3);
        expect_reg("R5 flag latched after pin idle", F_FLAG, 1'b1, 32'h000020);
        wr_reg(F_FLAG, 32'h000020, 1'b1);
        expect_reg("R6 clear after pin idle", F_FLAG, 1'b1, 32'h0);
        pins = 24'h000040;
        waitc(3);
        expect_reg("R4 flag bit6", F_FLAG, 1'b1, 32'h000040);
        wr_reg(F_LVL, 32'hFFFFBF, 1'b1);
        wr_reg(F_FLAG, 32'h000040, 1'b1);
        expect_reg("R6 clear after level inverted", F_FLAG, 1'b1, 32'h0);
        wr_reg(F_LVL, 32'hFFFFFF, 1'b1);
        pins = 24'h0;
        waitc(3);
        wr_reg(F_FLAG, 32'hFFFFFF, 1'b1);
        wr_reg(C_EN, 32'hFFFFFE, 1'b1);
        pins = 24'h000001;
        waitc(3);
        expect_reg("R4 disabled pin no flag", F_FLAG, 1'b1, 32'h0);
        pins = 24'h0;
        wr_reg(C_EN, 32'hFFFFFF, 1'b1);
    endtask

    task automatic t_owner;
        wr_reg(C_OWN, 32'h0000FF, 1'b1);
        expect_reg("R9 owned settings visible", R_OUT, 1'b0, 32'h000056);
        wr_reg(F_OUT, 32'hFFFFFF, 1'b1);
        expect_reg("R7 full write skips owned", F_OUT, 1'b1, 32'hFFFF56);
        wr_reg(R_OUT, 32'hFFFF00, 1'b0);
        expect_reg("R8 restricted write owned only", F_OUT, 1'b1, 32'hFFFF00);
        expect_reg("R8 unowned read zero", R_OUT, 1'b0, 32'h0);
        wr_reg(R_DIR, 32'hFFFFFF, 1'b0);
        expect_reg("R8 restricted dir write", F_DIR, 1'b1, 32'h00FFFF);
        wr_reg(C_OWN, 32'h0, 1'b1);
        expect_reg("R9 released pins hidden", R_DIR, 1'b0, 32'h0);
    endtask

    task automatic t_irq;
        wr_reg(C_OWN, 32'h000F00, 1'b1);
        wr_reg(F_MASK, 32'hFFFFFF, 1'b1);
        wr_reg(R_MASK, 32'h000F00, 1'b0);
        expect_reg("R7 mask combined", F_MASK, 1'b1, 32'hFFFFFF);
        chk("R10 irq idle", {30'd0, irq_f, irq_r}, 32'h0);
        pins = 24'h000200;
        waitc(3);
        chk("R10 restricted irq only", {30'd0, irq_f, irq_r}, 32'h1);
        expect_reg("R8 restricted flag view", R_FLAG, 1'b0, 32'h000200);
        pins = 24'h100200;
        waitc(3);
        chk("R10 both irqs", {30'd0, irq_f, irq_r}, 32'h3);
        pins = 24'h0;
        waitc(3);
        wr_reg(R_FLAG, 32'h000200, 1'b0);
        wr_reg(F_FLAG, 32'h100000, 1'b1);
        chk("R10 irqs cleared", {30'd0, irq_f, irq_r}, 32'h0);
        wr_reg(F_MASK, 32'h0, 1'b1);
        pins = 24'h100000;
        waitc(3);
        chk("R10 masked flag no irq", {30'd0, irq_f, irq_r}, 32'h0);
        expect_reg("R10 masked flag latched", F_FLAG, 1'b1, 32'h100000);
        pins = 24'h0;
        waitc(3);
        wr_reg(F_FLAG, 32'hFFFFFF, 1'b1);
        expect_reg("R10 masked flag clearable", F_FLAG, 1'b1, 32'h0);
    endtask

    task automatic t_priv;
        wr_reg(C_OWN, 32'hFFFFFF, 1'b0);
        expect_reg("R11 owner unprivileged write", C_OWN, 1'b1, 32'h000F00);
        expect_reg("R11 enable unprivileged read", C_EN, 1'b0, 32'h0);
        wr_reg(C_EN, 32'h0, 1'b0);
        expect_reg("R11 enable unprivileged write", C_EN, 1'b1, 32'hFFFFFF);
        wr_reg(F_OUT, 32'h0, 1'b0);
        expect_reg("R11 full unprivileged write", F_OUT, 1'b1, 32'hFFFF00);
        expect_reg("R11 full unprivileged read", F_OUT, 1'b0, 32'h0);
        wr_reg(R_OUT, 32'h000A00, 1'b1);
        expect_reg("R11 restricted privileged write", F_OUT, 1'b1, 32'hFFFA00);
    endtask

    task automatic t_mirror;
        wr_reg(R_MIR, 32'hFFFFFF, 1'b0);
        wr_reg(F_MIR, 32'h0, 1'b1);
        expect_reg("R12 snapshot read-only", F_MIR, 1'b1, 32'h00A5C3);
        expect_reg("R12 restricted snapshot view", R_MIR, 1'b0, 32'h000500);
    endtask

    initial begin
        waitc(3);
        rst_n = 1'b1;
        waitc(4);
        t_reset();
        t_drive();
        t_sync();
        t_flags();
        t_owner();
        t_irq();
        t_priv();
        t_mirror();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule